// File: doc/BRIEF.md
# External Interrupt and Event Line Controller

This block watches a set of external input lines and turns activity on them into two kinds of output. The first is a level interrupt request for each line, aimed at the CPU's interrupt controller. The second is a one-cycle hardware event pulse for each line, aimed at on-chip consumers such as a DMA engine or an ADC, so that they can start work without any software action.

Each input line is first brought into the clock domain by a two-flop synchronizer. Its edges are then found by comparing the synchronized value with the value one cycle earlier. Rising and falling detection are enabled by two separate per-line bits, so a line can react to one edge, to either edge, or to neither.

The detected edge is ORed with a per-line software trigger bit to form the line's request. The request sets a sticky pending bit. The interrupt output is the pending bit gated by an interrupt mask. The request also goes through a separate event mask to a small per-line pulse state machine, which emits exactly one pulse for each request. A flat register port with write strobe, address, write data and combinational read data configures the enables and masks, fires the software triggers and clears pending bits.

Top module: `ext_line_irq_evt`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `evt_o` are all 0.
- R2: A 0-to-1 change on `ext_i[i]` while the rising enable (address 0, bit i) is set makes pending bit i read 1. The bit is set on the third rising clock edge after the input change: two synchronizer stages, then the pending register.
- R3: A 1-to-0 change sets pending bit i only when the falling enable (address 1, bit i) is set. With both enables set, the line triggers on either edge. With the matching enable clear, the edge leaves the pending bit at 0.
- R4: Writing 1 to bit i of the software trigger register (address 4) sets pending bit i on the next clock edge, whatever the level of `ext_i[i]`. The trigger bit clears by itself one cycle after the write, so a read of address 4 then returns 0.
- R5: `irq_o[i]` is high exactly when pending bit i and the interrupt mask (address 2, bit i) are both 1. A mask of 0 blocks the output, but the pending bit still records the request.
- R6: With the event mask (address 3, bit i) set, each request on line i produces a pulse on `evt_o[i]` that lasts exactly one clock. The pulse appears in the same cycle that the pending bit is first seen. A request held high over consecutive cycles gives a single pulse. With the event mask clear there is no pulse. The event path does not depend on the interrupt mask.
- R7: Writing 1 to bit i of the pending register (address 5) clears that bit and leaves the other bits as they are. A pending bit stays set until it is cleared this way. If a new request and a clear reach the same bit in the same cycle, the bit stays set.
- R8: Addresses 0 to 3 read back the value last written. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_i | input | NLINES | External input lines, asynchronous to `clk` |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 rising enable, 1 falling enable, 2 interrupt mask, 3 event mask, 4 software trigger, 5 pending) |
| bus_wdata | input | NLINES | Write data, one bit per line |
| bus_rdata | output | NLINES | Read data for `bus_addr`, combinational |
| irq_o | output | NLINES | Masked interrupt request per line |
| evt_o | output | NLINES | One-cycle event pulse per line |

## Verification
The bench builds the block with the default of 19 lines. This puts the top line, bit 18, in the data path together with low-numbered lines, so it shows that the enables, masks and pending bits line up across the full width. It exercises the states of the pulse state machine on real lines: `EV_IDLE` to `EV_FIRE` on a single request, and `EV_FIRE` to `EV_HOLD` to `EV_IDLE` when software triggers fire on two consecutive cycles. It also lines up an edge request with a pending clear in the same cycle, to show that the new request wins.

// File: rtl/xec_pkg.sv
package xec_pkg;

    // Register port address width and register map
    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] REG_RISE = 3'd0;  // rising-edge enables
    localparam logic [REG_AW-1:0] REG_FALL = 3'd1;  // falling-edge enables
    localparam logic [REG_AW-1:0] REG_IMSK = 3'd2;  // interrupt mask
    localparam logic [REG_AW-1:0] REG_EMSK = 3'd3;  // event mask
    localparam logic [REG_AW-1:0] REG_SWT  = 3'd4;  // software trigger, self-clearing
    localparam logic [REG_AW-1:0] REG_PEND = 3'd5;  // pending, write-1-to-clear

    // Per-line event pulse generator states
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,   // no request seen
        EV_FIRE = 2'd1,   // pulse cycle
        EV_HOLD = 2'd2    // request still high after the pulse, wait for it to drop
    } ev_state_t;

endpackage

// File: rtl/xec_sync.sv
module xec_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    // One synchronizer chain plus history flop per line
    for (genvar g = 0; g < W; g++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= line_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise_o[g] =  sync_q & ~prev_q;
        assign fall_o[g] = ~sync_q &  prev_q;
    end

endmodule

// File: rtl/xec_regs.sv
module xec_regs
    import xec_pkg::*;
#(
    parameter int N = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      req_i,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      rise_en_o,
    output logic [N-1:0]      fall_en_o,
    output logic [N-1:0]      imask_o,
    output logic [N-1:0]      emask_o,
    output logic [N-1:0]      swt_o,
    output logic [N-1:0]      pend_o
);

    logic [N-1:0] rise_q, fall_q, imsk_q, emsk_q, swt_q, pend_q;
    logic         wr_rise, wr_fall, wr_imsk, wr_emsk, wr_swt, wr_pend;
    logic [N-1:0] clr_vec;

    assign wr_rise = we && (addr == REG_RISE);
    assign wr_fall = we && (addr == REG_FALL);
    assign wr_imsk = we && (addr == REG_IMSK);
    assign wr_emsk = we && (addr == REG_EMSK);
    assign wr_swt  = we && (addr == REG_SWT);
    assign wr_pend = we && (addr == REG_PEND);

    assign clr_vec = wr_pend ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            imsk_q <= '0;
            emsk_q <= '0;
            swt_q  <= '0;
            pend_q <= '0;
        end else begin
            if (wr_rise) rise_q <= wdata;
            if (wr_fall) fall_q <= wdata;
            if (wr_imsk) imsk_q <= wdata;
            if (wr_emsk) emsk_q <= wdata;
            // trigger holds for one cycle only
            swt_q  <= wr_swt ? wdata : '0;
            // new request wins over a clear in the same cycle
            pend_q <= (pend_q & ~clr_vec) | req_i;
        end
    end

    always_comb begin
        case (addr)
            REG_RISE: rdata = rise_q;
            REG_FALL: rdata = fall_q;
            REG_IMSK: rdata = imsk_q;
            REG_EMSK: rdata = emsk_q;
            REG_SWT:  rdata = swt_q;
            REG_PEND: rdata = pend_q;
            default:  rdata = '0;
        endcase
    end

    assign rise_en_o = rise_q;
    assign fall_en_o = fall_q;
    assign imask_o   = imsk_q;
    assign emask_o   = emsk_q;
    assign swt_o     = swt_q;
    assign pend_o    = pend_q;

endmodule

// File: rtl/xec_pulse.sv
module xec_pulse
    import xec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    ev_state_t st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EV_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EV_IDLE: st_d = req_i ? EV_FIRE : EV_IDLE;
            EV_FIRE: st_d = req_i ? EV_HOLD : EV_IDLE;
            EV_HOLD: st_d = req_i ? EV_HOLD : EV_IDLE;
            default: st_d = EV_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        pulse_o = (st_q == EV_FIRE);
    end

endmodule

// File: rtl/ext_line_irq_evt.sv
module ext_line_irq_evt
    import xec_pkg::*;
#(
    parameter int NLINES = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_i,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    output logic [NLINES-1:0] irq_o,
    output logic [NLINES-1:0] evt_o
);

    logic [NLINES-1:0] rise_det, fall_det;
    logic [NLINES-1:0] rise_en_q, fall_en_q, imask_q, emask_q, swt_q, pend_q;
    logic [NLINES-1:0] line_req, evt_req;

    xec_sync #(.W(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (ext_i),
        .rise_o (rise_det),
        .fall_o (fall_det)
    );

    // Shared request path: enabled edges ORed with software trigger
    assign line_req = (rise_det & rise_en_q) | (fall_det & fall_en_q) | swt_q;

    xec_regs #(.N(NLINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .req_i     (line_req),
        .rdata     (bus_rdata),
        .rise_en_o (rise_en_q),
        .fall_en_o (fall_en_q),
        .imask_o   (imask_q),
        .emask_o   (emask_q),
        .swt_o     (swt_q),
        .pend_o    (pend_q)
    );

    // Interrupt path
    assign irq_o = pend_q & imask_q;

    // Event path
    assign evt_req = line_req & emask_q;

    for (genvar g = 0; g < NLINES; g++) begin : g_evt
        xec_pulse u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (evt_req[g]),
            .pulse_o (evt_o[g])
        );
    end

endmodule

// File: rtl/xec_chk.sv
module xec_chk
    import xec_pkg::*;
#(
    parameter int N = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      irq_o,
    input logic [N-1:0]      evt_o,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      imask,
    input logic [N-1:0]      emask,
    input logic [N-1:0]      swt
);

    logic [N-1:0] clr_v, swt_wr_v;

    assign clr_v    = (bus_we && bus_addr == REG_PEND) ? bus_wdata : '0;
    assign swt_wr_v = (bus_we && bus_addr == REG_SWT)  ? bus_wdata : '0;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0 && evt_o == '0)); // R1

    AST_SWT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((swt & ~$past(swt_wr_v)) == '0)); // R4

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~(imask & pend)) == '0)); // R5

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & $past(evt_o)) == '0)); // R6

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(emask)) == '0)); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr_v) & ~pend) == '0)); // R7

endmodule

bind ext_line_irq_evt xec_chk #(.N(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .evt_o     (evt_o),
    .pend      (pend_q),
    .imask     (imask_q),
    .emask     (emask_q),
    .swt       (swt_q)
);

// File: tb/ext_line_irq_evt_test.sv
`timescale 1ns/1ps
module ext_line_irq_evt_test;
    import xec_pkg::*;

    localparam int N = 19;
    localparam logic [N-1:0] B1  = N'(1) << 1;
    localparam logic [N-1:0] B2  = N'(1) << 2;
    localparam logic [N-1:0] B3  = N'(1) << 3;
    localparam logic [N-1:0] B4  = N'(1) << 4;
    localparam logic [N-1:0] B7  = N'(1) << 7;
    localparam logic [N-1:0] B18 = N'(1) << 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  ext;
    logic          we;
    logic [2:0]    addr;
    logic [N-1:0]  wdata;
    logic [N-1:0]  rdata, irq, evt;
    int            n_cmp = 0;
    int            n_bad = 0;
    logic [N-1:0]  v;

    always #2.5 clk = ~clk;

    ext_line_irq_evt #(.NLINES(N)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (ext),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq),
        .evt_o     (evt)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // input change at a negedge -> pending visible after the third edge
    task automatic wait_sync();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic print_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 register reset value", v, '0);
        end
        chk("R1 irq after reset", irq, '0);
        chk("R1 evt after reset", evt, '0);
    endtask

    task automatic t_regs();
        wr(REG_RISE, 19'h5A5A5);
        wr(REG_FALL, 19'h2C3C3);
        wr(REG_IMSK, 19'h7FFFF);
        wr(REG_EMSK, 19'h10001);
        wr(3'd6, 19'h7FFFF);
        rd(REG_RISE, v); chk("R8 rise readback", v, 19'h5A5A5);
        rd(REG_FALL, v); chk("R8 fall readback", v, 19'h2C3C3);
        rd(REG_IMSK, v); chk("R8 imask readback", v, 19'h7FFFF);
        rd(REG_EMSK, v); chk("R8 emask readback", v, 19'h10001);
        rd(3'd6, v);     chk("R8 unused address 6", v, '0);
        rd(3'd7, v);     chk("R8 unused address 7", v, '0);
        wr(REG_RISE, '0);
        wr(REG_FALL, '0);
        wr(REG_IMSK, '0);
        wr(REG_EMSK, '0);
        rd(REG_PEND, v); chk("R8 config writes leave pending", v, '0);
    endtask

    task automatic t_rise();
        wr(REG_RISE, B3 | B4);
        wr(REG_IMSK, B3 | B4);
        wr(REG_EMSK, B3);
        ext = ext | B3 | B4;
        wait_sync();
        rd(REG_PEND, v); chk("R2 rising edge sets pending", v, B3 | B4);
        chk("R5 irq follows pending and mask", irq, B3 | B4);
        chk("R6 event pulse only on event-masked line", evt, B3);
        @(negedge clk);
        chk("R6 event pulse one cycle wide", evt, '0);
        rd(REG_PEND, v); chk("R7 pending stays set", v, B3 | B4);
        wr(REG_PEND, B3 | B4);
        rd(REG_PEND, v); chk("R7 write-1-to-clear", v, '0);
        ext = ext & ~B3;
        wait_sync();
        @(negedge clk);
        rd(REG_PEND, v); chk("R3 falling edge ignored without fall enable", v, '0);
        chk("R3 no irq from disabled edge", irq, '0);
    endtask

    task automatic t_both();
        wr(REG_RISE, B18);
        wr(REG_FALL, B18);
        ext = ext | B18;
        wait_sync();
        rd(REG_PEND, v); chk("R3 both enables rising edge", v, B18);
        wr(REG_PEND, B18);
        ext = ext & ~(B18 | B4);
        wait_sync();
        rd(REG_PEND, v); chk("R3 both enables falling edge, line 4 not enabled", v, B18);
        wr(REG_PEND, B18);
        wr(REG_RISE, '0);
        wr(REG_FALL, '0);
    endtask

    task automatic t_sw();
        wr(REG_EMSK, B7);
        wr(REG_SWT, B7);
        @(posedge clk);
        @(negedge clk);
        rd(REG_PEND, v); chk("R4 software trigger sets pending", v, B7);
        rd(REG_SWT, v);  chk("R4 software trigger self-clears", v, '0);
        chk("R5 interrupt mask 0 blocks irq", irq, '0);
        chk("R6 event pulse from software trigger", evt, B7);
        wr(REG_IMSK, B7);
        chk("R5 irq appears once mask set", irq, B7);
        chk("R6 no second pulse while pending held", evt, '0);
        wr(REG_PEND, B7);
        chk("R5 irq drops after clear", irq, '0);
        // request high on two consecutive cycles
        wr(REG_SWT, B7);
        wr(REG_SWT, B7);
        chk("R6 held request first pulse", evt, B7);
        @(negedge clk);
        chk("R6 held request no repeat", evt, '0);
        @(negedge clk);
        chk("R6 held request back to idle", evt, '0);
        wr(REG_PEND, B7);
        wr(REG_IMSK, '0);
        wr(REG_EMSK, '0);
    endtask

    task automatic t_w1c();
        wr(REG_SWT, B1 | B2);
        @(posedge clk);
        @(negedge clk);
        rd(REG_PEND, v); chk("R4 two-line software trigger", v, B1 | B2);
        wr(REG_PEND, B1);
        rd(REG_PEND, v); chk("R7 clear leaves other bits", v, B2);
        wr(REG_RISE, B2);
        ext = ext | B2;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(REG_PEND, B2);
        rd(REG_PEND, v); chk("R7 request wins over same-cycle clear", v, B2);
        wr(REG_PEND, B2);
        rd(REG_PEND, v); chk("R7 later clear succeeds", v, '0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        print_summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ext   = '0;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rise();
        t_both();
        t_sw();
        t_w1c();
        repeat (2) @(negedge clk);
        print_summary();
        $finish;
    end

endmodule